// File: doc/BRIEF.md
# Multicycle Program Counter Sequencer

This block keeps the program counter of a processor whose instructions take several clock cycles each, together with a branch-target holding register that is filled early in an instruction and read back later. On every rising clock edge it decides, from the control unit's strobes and the ALU's zero flag, whether the program counter changes. If it does change, the block also chooses where the new value comes from: the ALU result, the saved branch target, or a jump address. The block builds that jump address itself from the current PC and the instruction's 26-bit address field.

It also widens the instruction's 16-bit immediate into a signed word offset, sign-extended and multiplied by four. The ALU uses this offset as an operand when it computes a branch target during decode. The ALU, the instruction register and the control unit sit outside the block. The control unit drives the strobes, and the ALU result and zero flag come back in as inputs.

Top module: `pc_sequencer`

## Requirements
- R1: With `rst` high at a rising edge, `pc` and `target` both read 0 after that edge, whatever the write strobes are doing.
- R2: With `pc_wr` high and `pc_sel` = 2'b00, `pc` takes the value of `alu_res` at the rising edge.
- R3: A conditional write (`pc_wr_cond` high) updates `pc` only when `alu_zero` is 1. With `alu_zero` at 0 and `pc_wr` low, `pc` keeps its value. If `pc_wr` is high, the write happens whatever `alu_zero` is.
- R4: With the write enabled and `pc_sel` = 2'b01, `pc` takes the value `target` held before the edge, even when `target` is reloaded on that same edge.
- R5: With the write enabled and `pc_sel` = 2'b10, `pc` becomes {old `pc`[31:28], `ir_jump`[25:0], 2'b00}.
- R6: With `pc_sel` = 2'b11, `pc` keeps its value even when the write is enabled.
- R7: `target` loads `alu_res` at a rising edge only when `tgt_wr` is high, and otherwise holds. This happens independently of any PC write.
- R8: `offset_word` equals `ir_imm` sign-extended to 32 bits and shifted left by two, combinationally.
- R9: With both `pc_wr` and `pc_wr_cond` low, `pc` holds for every `pc_sel` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| alu_res | input | 32 | ALU result |
| alu_zero | input | 1 | ALU zero flag |
| ir_jump | input | 26 | Instruction address field, bits [25:0] |
| ir_imm | input | 16 | Instruction immediate, bits [15:0] |
| pc_wr | input | 1 | Unconditional PC write strobe |
| pc_wr_cond | input | 1 | PC write strobe qualified by `alu_zero` |
| pc_sel | input | 2 | Next-PC source: 00 ALU, 01 target, 10 jump, 11 hold |
| tgt_wr | input | 1 | Load strobe for the target register |
| pc | output | 32 | Current program counter |
| target | output | 32 | Branch-target register |
| offset_word | output | 32 | Sign-extended immediate times four |

## Verification
The assertions assume that every input is a known value, 0 or 1, at each rising edge outside reset. They also assume that `pc_sel` may take any value while the write strobes are low. The stimulus drives every input on the falling edge from a fixed table, so no input ever changes at the sampling edge. It also reaches the unused `pc_sel` = 2'b11 code while a write is enabled, which is the only place where a write strobe is meant to have no effect.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  parameter int XLEN   = 32;
  parameter int JFIELD = 26;
  parameter int IMMW   = 16;
  localparam int HIKEEP = XLEN - JFIELD - 2;

  typedef enum logic [1:0] {
    SRC_ALU  = 2'b00,
    SRC_TGT  = 2'b01,
    SRC_JMP  = 2'b10,
    SRC_HOLD = 2'b11
  } pc_src_e;
endpackage

// File: rtl/pc_offset_ext.sv
module pc_offset_ext #(
  parameter int IMMW = 16,
  parameter int XLEN = 32
) (
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] offset
);
  localparam int FILL = XLEN - IMMW - 2;
  // sign extension and a shift by two in one concatenation
  assign offset = {{FILL{imm[IMMW-1]}}, imm, 2'b00};
endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
  import pc_seq_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int JFIELD = 26
) (
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   alu_res,
  input  logic [XLEN-1:0]   tgt_val,
  input  logic [JFIELD-1:0] jfield,
  input  logic [1:0]        sel,
  input  logic              wr,
  input  logic              wr_cond,
  input  logic              zero,
  output logic [XLEN-1:0]   nxt_pc,
  output logic              load
);
  localparam int KEEP = XLEN - JFIELD - 2;

  logic [XLEN-1:0] jump_addr;
  logic            strobe;
  pc_src_e         src;

  assign src       = pc_src_e'(sel);
  assign jump_addr = {cur_pc[XLEN-1 -: KEEP], jfield, 2'b00};
  assign strobe    = wr | (wr_cond & zero);

  always_comb begin
    nxt_pc = cur_pc;
    load   = 1'b0;
    unique case (src)
      SRC_ALU:  begin nxt_pc = alu_res;   load = strobe; end
      SRC_TGT:  begin nxt_pc = tgt_val;   load = strobe; end
      SRC_JMP:  begin nxt_pc = jump_addr; load = strobe; end
      SRC_HOLD: begin nxt_pc = cur_pc;    load = 1'b0;   end
      default:  begin nxt_pc = cur_pc;    load = 1'b0;   end
    endcase
  end
endmodule

// File: rtl/pc_state_reg.sv
module pc_state_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int XLEN   = pc_seq_pkg::XLEN,
  parameter int JFIELD = pc_seq_pkg::JFIELD,
  parameter int IMMW   = pc_seq_pkg::IMMW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   alu_res,
  input  logic              alu_zero,
  input  logic [JFIELD-1:0] ir_jump,
  input  logic [IMMW-1:0]   ir_imm,
  input  logic              pc_wr,
  input  logic              pc_wr_cond,
  input  logic [1:0]        pc_sel,
  input  logic              tgt_wr,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   target,
  output logic [XLEN-1:0]   offset_word
);
  logic [XLEN-1:0] nxt_pc;
  logic            pc_load;

  pc_offset_ext #(.IMMW(IMMW), .XLEN(XLEN)) u_ext (
    .imm    (ir_imm),
    .offset (offset_word)
  );

  pc_next_mux #(.XLEN(XLEN), .JFIELD(JFIELD)) u_mux (
    .cur_pc  (pc),
    .alu_res (alu_res),
    .tgt_val (target),
    .jfield  (ir_jump),
    .sel     (pc_sel),
    .wr      (pc_wr),
    .wr_cond (pc_wr_cond),
    .zero    (alu_zero),
    .nxt_pc  (nxt_pc),
    .load    (pc_load)
  );

  pc_state_reg #(.W(XLEN)) u_pc_reg (
    .clk (clk),
    .rst (rst),
    .en  (pc_load),
    .d   (nxt_pc),
    .q   (pc)
  );

  pc_state_reg #(.W(XLEN)) u_tgt_reg (
    .clk (clk),
    .rst (rst),
    .en  (tgt_wr),
    .d   (alu_res),
    .q   (target)
  );
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int XLEN   = 32,
  parameter int JFIELD = 26,
  parameter int IMMW   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [XLEN-1:0]   alu_res,
  input logic              alu_zero,
  input logic [JFIELD-1:0] ir_jump,
  input logic [IMMW-1:0]   ir_imm,
  input logic              pc_wr,
  input logic              pc_wr_cond,
  input logic [1:0]        pc_sel,
  input logic              tgt_wr,
  input logic [XLEN-1:0]   pc,
  input logic [XLEN-1:0]   target,
  input logic [XLEN-1:0]   offset_word
);
  localparam int KEEP = XLEN - JFIELD - 2;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pc == '0 && target == '0));

  a_r2_alu_source: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && pc_sel == 2'b00) |=> pc == $past(alu_res));

  a_r3_cond_blocked: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && pc_wr_cond && !alu_zero) |=> $stable(pc));

  a_r4_target_source: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && pc_sel == 2'b01) |=> pc == $past(target));

  a_r5_jump_source: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && pc_sel == 2'b10) |=>
      pc == {$past(pc[XLEN-1 -: KEEP]), $past(ir_jump), 2'b00});

  a_r6_unused_code_holds: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'b11) |=> $stable(pc));

  a_r7_target_load: assert property (@(posedge clk) disable iff (rst)
    tgt_wr |=> target == $past(alu_res));

  a_r7_target_hold: assert property (@(posedge clk) disable iff (rst)
    !tgt_wr |=> $stable(target));

  a_r8_offset_scaled: assert property (@(posedge clk) disable iff (rst)
    $signed(offset_word) == $signed(ir_imm) * 4);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && !pc_wr_cond) |=> $stable(pc));
endmodule

bind pc_sequencer pc_sequencer_chk #(
  .XLEN(XLEN), .JFIELD(JFIELD), .IMMW(IMMW)
) u_chk (.*);

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] alu_res = '0;
  logic        alu_zero = 1'b0;
  logic [25:0] ir_jump = '0;
  logic [15:0] ir_imm = '0;
  logic        pc_wr = 1'b0;
  logic        pc_wr_cond = 1'b0;
  logic [1:0]  pc_sel = 2'b00;
  logic        tgt_wr = 1'b0;
  logic [31:0] pc, target, offset_word;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  pc_sequencer i_pc_sequencer (.*);

  typedef struct packed {
    logic        wr;
    logic        cond;
    logic        zero;
    logic [1:0]  sel;
    logic        tw;
    logic [31:0] alu;
    logic [25:0] jf;
    logic [31:0] exp_pc;
    logic [31:0] exp_tgt;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    // R2: unconditional write from the ALU
    '{1'b1,1'b0,1'b0,2'b00,1'b0,32'h0000_0004,26'h0,       32'h0000_0004,32'h0,         8'd2},
    // R7: target loads, PC untouched
    '{1'b0,1'b0,1'b0,2'b00,1'b1,32'h0000_0040,26'h0,       32'h0000_0004,32'h0000_0040, 8'd7},
    // R3: conditional write with zero low does nothing
    '{1'b0,1'b1,1'b0,2'b01,1'b0,32'h0000_0099,26'h0,       32'h0000_0004,32'h0000_0040, 8'd3},
    // R4: conditional write taken, target source
    '{1'b0,1'b1,1'b1,2'b01,1'b0,32'h0000_0099,26'h0,       32'h0000_0040,32'h0000_0040, 8'd4},
    // R2: load a PC with a nonzero high nibble
    '{1'b1,1'b0,1'b0,2'b00,1'b0,32'h9000_0010,26'h0,       32'h9000_0010,32'h0000_0040, 8'd2},
    // R5: jump keeps the old top four bits
    '{1'b1,1'b0,1'b0,2'b10,1'b0,32'h0000_0000,26'h0123456, 32'h9048_D158,32'h0000_0040, 8'd5},
    // R6: unused source code with write enabled holds
    '{1'b1,1'b1,1'b1,2'b11,1'b0,32'h0000_DEAD,26'h0,       32'h9048_D158,32'h0000_0040, 8'd6},
    // R9: no strobes, PC holds
    '{1'b0,1'b0,1'b1,2'b00,1'b0,32'h0000_1234,26'h0,       32'h9048_D158,32'h0000_0040, 8'd9},
    // R4 and R7 on the same edge: PC takes old target
    '{1'b1,1'b0,1'b0,2'b01,1'b1,32'h0000_0800,26'h0,       32'h0000_0040,32'h0000_0800, 8'd4},
    // R5: all-ones address field, high nibble zero
    '{1'b1,1'b1,1'b1,2'b10,1'b0,32'h0000_0000,26'h3FF_FFFF,32'h0FFF_FFFC,32'h0000_0800, 8'd5},
    // R3: unconditional strobe wins over zero low
    '{1'b1,1'b1,1'b0,2'b00,1'b0,32'h0000_1000,26'h0,       32'h0000_1000,32'h0000_0800, 8'd3}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    pc_wr = v.wr; pc_wr_cond = v.cond; alu_zero = v.zero;
    pc_sel = v.sel; tgt_wr = v.tw; alu_res = v.alu; ir_jump = v.jf;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check("R1 pc after reset", pc, 32'h0);
    check("R1 target after reset", target, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("R%0d pc vec%0d", VECS[i].req, i), pc, VECS[i].exp_pc);
      check($sformatf("R%0d target vec%0d", VECS[i].req, i), target, VECS[i].exp_tgt);
    end

    // R1: reset overrides simultaneous writes
    rst = 1'b1;
    apply('{1'b1,1'b0,1'b0,2'b00,1'b1,32'h0000_0055,26'h0,32'h0,32'h0,8'd1});
    check("R1 pc reset beats write", pc, 32'h0);
    check("R1 target reset beats load", target, 32'h0);
    rst = 1'b0;
    pc_wr = 1'b0; tgt_wr = 1'b0;

    // R8: immediate widening
    ir_imm = 16'h8001; #1;
    check("R8 negative offset", offset_word, 32'hFFFE_0004);
    ir_imm = 16'h7FFF; #1;
    check("R8 largest positive offset", offset_word, 32'h0001_FFFC);
    ir_imm = 16'hFFFF; #1;
    check("R8 minus one offset", offset_word, 32'hFFFF_FFFC);
    ir_imm = 16'h0000; #1;
    check("R8 zero offset", offset_word, 32'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule